// File: doc/BRIEF.md
# Byte-Wide Flash Command Interpreter

This block models the command logic of a byte-wide flash memory whose write protection is always on. Every change to the stored data has to be unlocked by a short sequence of command writes. Writes arrive as single-cycle strobes that carry a 17-bit address and an 8-bit data byte. A sequence that is recognised either programs one byte or erases the whole array. The array is held in a simple dual-port memory that can map to block RAM, and it is indexed by the low `ARR_AW` bits of the address.

Programming a byte needs the full unlock prefix every time. A data write that follows a completed program does nothing unless it is preceded by a new prefix. The address bits above bit 14 take no part in command matching. After a program or an erase the block raises a busy flag for a fixed number of clocks. While busy is high it ignores all writes and returns no read data. Reads made while the block is idle return the stored byte one cycle later.

Top module: `flash_cmd_model`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy_o` and `rvalid_o` are low, and the command decoder is idle.
- R2: The writes 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555, followed by one more write of data D to address A, set the byte at index A[ARR_AW-1:0] to its old value AND D. Programming can only clear bits.
- R3: Once a program has finished, a further data write made without a new three-write prefix leaves the array unchanged.
- R4: The writes 0xAA to 0x5555, 0x55 to 0x2AAA, 0x80 to 0x5555, 0xAA to 0x5555, 0x55 to 0x2AAA and 0x10 to 0x5555, in that order, set every byte of the array to 0xFF.
- R5: A write whose address or data does not match the next expected cycle returns the decoder to idle, and that write is not taken as the start of a new sequence. The sequence it interrupted has no effect on the array and does not raise busy.
- R6: Command cycles are matched only on address bits 14:0. For example, 0xAA to 0x15555 counts as a valid first cycle.
- R7: The write that completes a program or an erase raises `busy_o` from the next cycle. Busy stays high for max(PROG_BUSY,3) cycles after a program, and for max(ERASE_BUSY, 2^ARR_AW) cycles after an erase.
- R8: A write accepted while `busy_o` is high changes neither the decoder state nor the array.
- R9: A read strobe (`re_i` high, `we_i` low) made while busy is low gives `rvalid_o` high in the next cycle, with `rdata_o` equal to the byte at index addr[ARR_AW-1:0]. A read made while busy is high gives no `rvalid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| we_i | input | 1 | Write strobe, one write per cycle |
| re_i | input | 1 | Read strobe, ignored when `we_i` is high |
| addr_i | input | 17 | Byte address for writes and reads |
| wdata_i | input | 8 | Write data or command byte |
| rdata_o | output | 8 | Read data, valid when `rvalid_o` is high |
| rvalid_o | output | 1 | Read data valid, one cycle after an accepted read |
| busy_o | output | 1 | An operation is in progress |

## Verification
Read data is due in the cycle after the read strobe's edge. The driver task pushes the expected byte from its own model when it issues the read, and the monitor pops it at the next falling edge where `rvalid_o` is high. Busy is due in the cycle right after the edge that takes the final command write. The bench counts falling edges with busy high, starting at that point, and compares the count with the program or erase length. Writes and reads that should be ignored are checked one cycle later: the bench looks for busy staying low or `rvalid_o` staying low, or it reads the affected location back once the block is idle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int CMP_W = 15;

  localparam logic [CMP_W-1:0] UNLOCK_ADDR_A = 15'h5555;
  localparam logic [CMP_W-1:0] UNLOCK_ADDR_B = 15'h2AAA;

  localparam logic [7:0] KEY_FIRST   = 8'hAA;
  localparam logic [7:0] KEY_SECOND  = 8'h55;
  localparam logic [7:0] OP_PROGRAM  = 8'hA0;
  localparam logic [7:0] OP_ERASE_SU = 8'h80;
  localparam logic [7:0] OP_CHIP_ERS = 8'h10;

  typedef enum logic [2:0] {
    DS_IDLE,
    DS_KEY1,
    DS_KEY2,
    DS_PROG,
    DS_ESU,
    DS_EKEY1,
    DS_EKEY2
  } dec_state_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RDOLD,
    PH_WRNEW,
    PH_SWEEP,
    PH_HOLD
  } eng_phase_t;

endpackage

// File: rtl/flash_seq_decoder.sv
module flash_seq_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic              busy_i,
  input  logic [CMP_W-1:0]  cmd_addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              prog_go_o,
  output logic              erase_go_o
);

  dec_state_t state_q, state_d;
  logic       take;
  logic       at_a, at_b;

  assign take = we_i && !busy_i;
  assign at_a = (cmd_addr_i == UNLOCK_ADDR_A);
  assign at_b = (cmd_addr_i == UNLOCK_ADDR_B);

  always_comb begin
    state_d    = state_q;
    prog_go_o  = 1'b0;
    erase_go_o = 1'b0;
    if (take) begin
      state_d = DS_IDLE;
      unique case (state_q)
        DS_IDLE:  if (at_a && data_i == KEY_FIRST)  state_d = DS_KEY1;
        DS_KEY1:  if (at_b && data_i == KEY_SECOND) state_d = DS_KEY2;
        DS_KEY2: begin
          if (at_a && data_i == OP_PROGRAM)       state_d = DS_PROG;
          else if (at_a && data_i == OP_ERASE_SU) state_d = DS_ESU;
        end
        DS_PROG:  prog_go_o = 1'b1;
        DS_ESU:   if (at_a && data_i == KEY_FIRST)  state_d = DS_EKEY1;
        DS_EKEY1: if (at_b && data_i == KEY_SECOND) state_d = DS_EKEY2;
        DS_EKEY2: if (at_a && data_i == OP_CHIP_ERS) erase_go_o = 1'b1;
        default:  state_d = DS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= DS_IDLE;
    else     state_q <= state_d;
  end

  // R8: while busy, the decoder holds its state
  a_r8_hold_when_busy: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> state_q == $past(state_q));

  // R5: after a firing write the decoder is back at idle
  a_r5_idle_after_go: assert property (@(posedge clk) disable iff (rst)
    (prog_go_o || erase_go_o) |=> state_q == DS_IDLE);

  // R1: reset leaves the decoder idle
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> state_q == DS_IDLE);

endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ARR_AW     = 8,
  parameter int PROG_BUSY  = 4,
  parameter int ERASE_BUSY = 300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_go_i,
  input  logic              erase_go_i,
  input  logic [ARR_AW-1:0] go_addr_i,
  input  logic [DATA_W-1:0] go_data_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              mem_re_o,
  output logic [ARR_AW-1:0] mem_raddr_o,
  output logic              mem_we_o,
  output logic [ARR_AW-1:0] mem_waddr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);

  localparam int DEPTH     = 1 << ARR_AW;
  localparam int PROG_LEN  = (PROG_BUSY < 3) ? 3 : PROG_BUSY;
  localparam int ERASE_LEN = (ERASE_BUSY < DEPTH) ? DEPTH : ERASE_BUSY;
  localparam int CNT_W     = $clog2(ERASE_LEN + 1);

  eng_phase_t        phase_q;
  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ARR_AW-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [ARR_AW-1:0] sweep_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      sweep_q <= '0;
    end else if (!busy_q) begin
      if (prog_go_i) begin
        busy_q  <= 1'b1;
        cnt_q   <= CNT_W'(PROG_LEN - 1);
        phase_q <= PH_RDOLD;
        addr_q  <= go_addr_i;
        data_q  <= go_data_i;
      end else if (erase_go_i) begin
        busy_q  <= 1'b1;
        cnt_q   <= CNT_W'(ERASE_LEN - 1);
        phase_q <= PH_SWEEP;
        sweep_q <= '0;
      end
    end else begin
      if (cnt_q == '0) begin
        busy_q  <= 1'b0;
        phase_q <= PH_IDLE;
      end else begin
        cnt_q <= cnt_q - 1'b1;
        unique case (phase_q)
          PH_RDOLD: phase_q <= PH_WRNEW;
          PH_WRNEW: phase_q <= PH_HOLD;
          PH_SWEEP: begin
            sweep_q <= sweep_q + 1'b1;
            if (sweep_q == {ARR_AW{1'b1}}) phase_q <= PH_HOLD;
          end
          default: phase_q <= phase_q;
        endcase
      end
    end
  end

  always_comb begin
    mem_re_o    = (phase_q == PH_RDOLD);
    mem_raddr_o = addr_q;
    mem_we_o    = 1'b0;
    mem_waddr_o = addr_q;
    mem_wdata_o = mem_rdata_i & data_q;
    if (phase_q == PH_WRNEW) begin
      mem_we_o = 1'b1;
    end else if (phase_q == PH_SWEEP) begin
      mem_we_o    = 1'b1;
      mem_waddr_o = sweep_q;
      mem_wdata_o = {DATA_W{1'b1}};
    end
  end

  assign busy_o = busy_q;

  // R7: busy only starts from an accepted command
  a_r7_busy_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(prog_go_i || erase_go_i));

  // R8: the decoder never fires while an operation runs
  a_r8_no_go_busy: assert property (@(posedge clk) disable iff (rst)
    (prog_go_i || erase_go_i) |-> !busy_q);

  // R2: a program write never sets a bit the command data had clear
  a_r2_only_clears: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && phase_q == PH_WRNEW) |-> ((mem_wdata_o & ~data_q) == '0));

  // R4: the erase sweep writes all ones
  a_r4_sweep_ones: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o && phase_q == PH_SWEEP) |-> (&mem_wdata_o));

endmodule

// File: rtl/flash_mem_array.sv
module flash_mem_array #(
  parameter int DATA_W = 8,
  parameter int ARR_AW = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ARR_AW-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ARR_AW-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ARR_AW;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) store[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_i) rdata_o <= store[raddr_i];
  end

endmodule

// File: rtl/flash_cmd_model.sv
module flash_cmd_model
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int ARR_AW     = 8,
  parameter int PROG_BUSY  = 4,
  parameter int ERASE_BUSY = 300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              busy_o
);

  logic              prog_go, erase_go;
  logic              eng_re, eng_we;
  logic [ARR_AW-1:0] eng_raddr, eng_waddr;
  logic [DATA_W-1:0] eng_wdata, mem_rdata;
  logic              user_re, rvalid_q;
  logic              unused_addr_hi;

  assign unused_addr_hi = ^addr_i[ADDR_W-1:CMP_W];

  flash_seq_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .we_i       (we_i),
    .busy_i     (busy_o),
    .cmd_addr_i (addr_i[CMP_W-1:0]),
    .data_i     (wdata_i),
    .prog_go_o  (prog_go),
    .erase_go_o (erase_go)
  );

  flash_op_engine #(
    .DATA_W(DATA_W), .ARR_AW(ARR_AW),
    .PROG_BUSY(PROG_BUSY), .ERASE_BUSY(ERASE_BUSY)
  ) u_eng (
    .clk         (clk),
    .rst         (rst),
    .prog_go_i   (prog_go),
    .erase_go_i  (erase_go),
    .go_addr_i   (addr_i[ARR_AW-1:0]),
    .go_data_i   (wdata_i),
    .mem_rdata_i (mem_rdata),
    .busy_o      (busy_o),
    .mem_re_o    (eng_re),
    .mem_raddr_o (eng_raddr),
    .mem_we_o    (eng_we),
    .mem_waddr_o (eng_waddr),
    .mem_wdata_o (eng_wdata)
  );

  assign user_re = re_i && !we_i && !busy_o;

  flash_mem_array #(.DATA_W(DATA_W), .ARR_AW(ARR_AW)) u_mem (
    .clk     (clk),
    .we_i    (eng_we),
    .waddr_i (eng_waddr),
    .wdata_i (eng_wdata),
    .re_i    (user_re || eng_re),
    .raddr_i (busy_o ? eng_raddr : addr_i[ARR_AW-1:0]),
    .rdata_o (mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) rvalid_q <= 1'b0;
    else     rvalid_q <= user_re;
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = mem_rdata;

  // R1: outputs quiet after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!busy_o && !rvalid_o));

  // R9: read data only follows an idle-time read strobe
  a_r9_valid_cause: assert property (@(posedge clk) disable iff (rst)
    rvalid_o |-> $past(re_i && !we_i && !busy_o));

  // R9: no engine memory access collides with a user read
  a_r9_no_port_clash: assert property (@(posedge clk) disable iff (rst)
    eng_re |-> !user_re);

endmodule

// File: tb/tb_flash_cmd_model.sv
module tb_flash_cmd_model;

  localparam int PB    = 4;
  localparam int EB    = 300;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int PLEN  = (PB < 3) ? 3 : PB;
  localparam int ELEN  = (EB < DEPTH) ? DEPTH : EB;

  logic        clk = 1'b0;
  logic        rst;
  logic        we, re;
  logic [16:0] addr;
  logic [7:0]  wdata, rdata;
  logic        rvalid, busy;

  always #5 clk = ~clk;

  flash_cmd_model #(.ADDR_W(17), .DATA_W(8), .ARR_AW(AW),
                    .PROG_BUSY(PB), .ERASE_BUSY(EB)) dut (
    .clk(clk), .rst(rst), .we_i(we), .re_i(re), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .busy_o(busy)
  );

  typedef struct {
    logic [7:0] d;
    string      tag;
  } exp_t;

  exp_t       q[$];
  exp_t       got;
  logic [7:0] mdl [DEPTH];
  int         n_chk = 0;
  int         n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // monitor: compare each returned read with the scoreboard
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R9 unexpected rvalid", 1, 0);
      end else begin
        got = q.pop_front();
        chk(rdata == got.d, got.tag, rdata, got.d);
      end
    end
  end

  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [16:0] a, input string tag);
    re = 1'b1; addr = a;
    q.push_back('{mdl[a[AW-1:0]], tag});
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic prefix(input logic [16:0] hi);
    wr(hi | 17'h05555, 8'hAA);
    wr(hi | 17'h02AAA, 8'h55);
    wr(hi | 17'h05555, 8'hA0);
  endtask

  task automatic prog(input logic [16:0] a, input logic [7:0] d, input logic [16:0] hi);
    int n;
    prefix(hi);
    wr(a, d);
    busy_len(n);
    chk(n == PLEN, "R7 program busy length", n, PLEN);
    mdl[a[AW-1:0]] &= d;
  endtask

  task automatic erase();
    int n;
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h80);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h10);
    busy_len(n);
    chk(n == ELEN, "R7 erase busy length", n, ELEN);
    for (int i = 0; i < DEPTH; i++) mdl[i] = 8'hFF;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int n;
    rst = 1'b1; we = 1'b0; re = 1'b0; addr = '0; wdata = '0;
    for (int i = 0; i < DEPTH; i++) mdl[i] = 8'h00;
    idle(3);
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    chk(rvalid == 1'b0, "R1 rvalid in reset", rvalid, 0);
    rst = 1'b0;
    idle(1);
    chk(busy == 1'b0 && rvalid == 1'b0, "R1 after reset", {busy, rvalid}, 0);

    // R4: chip erase sets every byte
    erase();
    rd(17'h00000, "R4 erased byte 0");
    rd(17'h000FF, "R4 erased top byte");
    rd(17'h01000, "R4 erased 0x1000");
    idle(2);

    // R2: first byte programmed
    prog(17'h01000, 8'hBA, 17'h0);
    rd(17'h01000, "R2 programmed 0xBA");
    idle(2);

    // R3: a second data write without prefix is dropped
    wr(17'h01001, 8'hAB);
    chk(busy == 1'b0, "R3 no busy on lone write", busy, 0);
    rd(17'h01001, "R3 lone write ignored");
    idle(2);
    prog(17'h01001, 8'hAB, 17'h0);
    rd(17'h01001, "R2 second byte with new prefix");
    idle(2);

    // R2: re-program only clears bits
    prog(17'h01000, 8'h0F, 17'h0);
    rd(17'h01000, "R2 AND with old value");
    idle(2);

    // R5: wrong command byte aborts; later A0 does not resume
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h33);
    wr(17'h05555, 8'hA0); wr(17'h01002, 8'h00);
    chk(busy == 1'b0, "R5 aborted program no busy", busy, 0);
    rd(17'h01002, "R5 aborted by bad data");
    idle(2);

    // R5: wrong address in cycle 2 aborts
    wr(17'h05555, 8'hAA); wr(17'h01234, 8'h55); wr(17'h05555, 8'hA0);
    wr(17'h01003, 8'h00);
    chk(busy == 1'b0, "R5 bad address no busy", busy, 0);
    rd(17'h01003, "R5 aborted by bad address");
    idle(2);

    // R5: wrong final erase byte
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h80);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h30);
    chk(busy == 1'b0, "R5 erase aborted no busy", busy, 0);
    rd(17'h01000, "R5 erase aborted data kept");
    idle(2);

    // R6: upper address bits ignored for command match
    prog(17'h00005, 8'h5A, 17'h10000);
    rd(17'h00005, "R6 high-bit command addresses");
    rd(17'h10105, "R2 index uses low address bits");
    idle(2);

    // R8: a prefix sent during busy is ignored
    prefix(17'h0);
    wr(17'h00010, 8'hF0);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0);
    mdl[8'h10] &= 8'hF0;
    busy_len(n);
    wr(17'h00006, 8'h00);
    chk(busy == 1'b0, "R8 no program after busy prefix", busy, 0);
    rd(17'h00006, "R8 writes during busy ignored");
    rd(17'h00010, "R2 byte programmed before R8 test");
    idle(2);

    // R9: read during busy returns nothing
    prefix(17'h0);
    wr(17'h00007, 8'hC3);
    re = 1'b1; addr = 17'h00007;
    @(negedge clk);
    re = 1'b0;
    chk(rvalid == 1'b0, "R9 no rvalid while busy", rvalid, 0);
    mdl[7] &= 8'hC3;
    busy_len(n);
    rd(17'h00007, "R9 read after busy");
    idle(2);

    // R4: second erase clears programmed bytes
    erase();
    rd(17'h01000, "R4 re-erase 0x1000");
    rd(17'h00005, "R4 re-erase 0x05");
    rd(17'h00007, "R4 re-erase 0x07");
    idle(3);
    chk(q.size() == 0, "R9 all reads returned", q.size(), 0);

    summary();
    $finish;
  end

endmodule